// File: doc/BRIEF.md
# Bus Cycle Utilization Accountant

This block sits beside a bus master and charges every completed bus transaction with the number of bus clock cycles it occupied. Each transaction arrives as a one-cycle report carrying its kind (DMA burst read from host memory, DMA burst write to host memory, host write to a device register, host read of a device register), its count of data cycles and its measured memory-latency cycles. The block adds the fixed overhead that belongs to each kind. Only the per-transaction cost is modelled: no bus signalling, arbitration or payload passes through it. Each data cycle carries 4 bytes, so a P-byte packet is reported with P/4 data cycles.

Cycles are summed over a measurement window whose length, in clock cycles, comes from an input. When a window closes, the block publishes the total charged cycles and the read and write subtotals, and pulses a strobe. A sequential divider then works out the charged total as a fraction of the window length, scaled so that a full window reads 65535. It pulses a second strobe when the fraction is ready. Software or a performance monitor samples the outputs on the two strobes.

Top module: `bus_util_acct`

## Requirements
- R1: A report of kind 0 (DMA burst read) charges 3 + lat + data cycles. The 3 is one address cycle, one turnaround after it and one turnaround at the end.
- R2: A report of kind 1 (DMA burst write) charges 2 + lat + data cycles. There is no turnaround after the address.
- R3: A report of kind 2 (host register write) or kind 3 (host register read) charges exactly 7 cycles, whatever the data and latency fields hold.
- R4: Kinds 0 and 3 are counted in `rd_cyc`, and kinds 1 and 2 are counted in `wr_cyc`. `total_cyc` holds all four kinds. Reports on consecutive cycles all add up.
- R5: A window lasts `win_len` cycles, and a value of 0 acts as 1. On the closing cycle the totals are latched and `win_done` is high for one cycle. A report that arrives on the closing cycle is counted in the next window.
- R6: Each running sum saturates at all ones and never wraps.
- R7: `util_frac` equals floor(total × 65535 / window). It is 65535 when the total is at least the window length. It is updated with a one-cycle `util_done` exactly 16 cycles after `win_done`, provided the window is at least 17 cycles long.
- R8: A synchronous active-low reset clears all sums, outputs and strobes. The first window starts on the first cycle after reset is released.
- R9: While `txn_valid` is low, nothing is charged, whatever the other report fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_len | input | WIN_W | Window length in clock cycles (0 acts as 1) |
| txn_valid | input | 1 | One-cycle report of a finished transaction |
| txn_kind | input | 2 | 0 DMA read, 1 DMA write, 2 host write, 3 host read |
| txn_data | input | DATA_W | Data cycles of the transaction |
| txn_lat | input | LAT_W | Memory latency cycles of the transaction |
| total_cyc | output | ACC_W | Charged cycles of the last closed window |
| rd_cyc | output | ACC_W | Read-kind charged cycles of the last closed window |
| wr_cyc | output | ACC_W | Write-kind charged cycles of the last closed window |
| util_frac | output | FRAC_W | Utilization, full scale 65535 |
| win_done | output | 1 | One-cycle strobe when a window closes |
| util_done | output | 1 | One-cycle strobe when `util_frac` is updated |

## Verification
The hardest case to reach from the ports is a report that lands exactly on the window's closing cycle. The bench counts clock cycles from an observed `win_done` strobe and drives one report on the last cycle of a window and another on the closing cycle, so that the two are split between adjacent windows. Saturation of a 32-bit sum would take millions of cycles, so the bench builds the block with a 12-bit accumulator width and feeds back-to-back maximum-cost reads. The bench also measures the divider's latency by counting cycles between the two strobes for every table vector.

// File: rtl/bua_pkg.sv
// Shared definitions for the bus cycle accountant.
// Assumes the kind encoding below is fixed by the reporting master.
package bua_pkg;

    typedef enum logic [1:0] {
        KIND_DMA_RD  = 2'd0,
        KIND_DMA_WR  = 2'd1,
        KIND_HOST_WR = 2'd2,
        KIND_HOST_RD = 2'd3
    } txn_kind_e;

    // Fixed overheads in bus cycles per access kind
    localparam int unsigned DMA_RD_OVH = 3;
    localparam int unsigned DMA_WR_OVH = 2;
    localparam int unsigned HOST_COST  = 7;

    // Number of parallel running sums: total, read, write
    localparam int unsigned N_LANES = 3;

endpackage

// File: rtl/bua_cost.sv
// Converts one transaction report into the bus cycles it consumed and
// classifies it as read or write. Purely combinational.
// Assumes COST_W is wide enough for the largest overhead + lat + data.
module bua_cost
    import bua_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LAT_W  = 8,
    parameter int unsigned COST_W = 10
) (
    input  logic [1:0]        kind,
    input  logic [DATA_W-1:0] data_cyc,
    input  logic [LAT_W-1:0]  lat_cyc,
    output logic [COST_W-1:0] cost,
    output logic              is_read
);

    logic [COST_W-1:0] var_part;

    // Variable part shared by both DMA kinds
    always_comb var_part = COST_W'(data_cyc) + COST_W'(lat_cyc);

    // Select overhead and direction by kind
    always_comb begin
        unique case (txn_kind_e'(kind))
            KIND_DMA_RD: begin
                cost    = var_part + COST_W'(DMA_RD_OVH);
                is_read = 1'b1;
            end
            KIND_DMA_WR: begin
                cost    = var_part + COST_W'(DMA_WR_OVH);
                is_read = 1'b0;
            end
            KIND_HOST_WR: begin
                cost    = COST_W'(HOST_COST);
                is_read = 1'b0;
            end
            default: begin
                cost    = COST_W'(HOST_COST);
                is_read = 1'b1;
            end
        endcase
    end

    // R3: register accesses never depend on data or latency fields
    always_comb begin
        if (kind[1]) assert_host_fixed_R3: assert (cost == COST_W'(7));
    end

endmodule

// File: rtl/bua_window.sv
// Measurement window timer. Raises tick on the closing cycle of every
// window of win_len cycles; a length of 0 is treated as 1.
// Assumes win_len may change at any time; a shorter value closes at once.
module bua_window #(
    parameter int unsigned WIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    output logic             tick,
    output logic [WIN_W-1:0] win_eff
);

    logic [WIN_W-1:0] cnt_q;

    // Effective length with zero mapped to one
    always_comb win_eff = (win_len == '0) ? WIN_W'(1) : win_len;

    // Boundary detect
    always_comb tick = (cnt_q >= win_eff);

    // Cycle counter, restarts at one after a boundary
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= WIN_W'(1);
        else           cnt_q <= cnt_q + WIN_W'(1);
    end

    // R5: a window longer than one cycle never closes on two adjacent cycles
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && win_eff > WIN_W'(1)) |=> (!tick || win_eff <= WIN_W'(1)));

endmodule

// File: rtl/bua_sat_acc.sv
// Saturating running sum. clr restarts the sum; an addition presented in
// the same cycle as clr becomes the first term of the new sum.
// Assumes add_val is unsigned.
module bua_sat_acc #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned ADD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add_val,
    output logic [ACC_W-1:0] acc_q
);

    localparam int unsigned SUM_W = ((ACC_W > ADD_W) ? ACC_W : ADD_W) + 1;
    localparam logic [SUM_W-1:0] ACC_MAX = SUM_W'({ACC_W{1'b1}});

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] acc_d;

    // Next value with clamp at all ones
    always_comb begin
        base  = clr ? '0 : SUM_W'(acc_q);
        sum   = base + (add_en ? SUM_W'(add_val) : '0);
        acc_d = (sum > ACC_MAX) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    end

    // Sum register
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R6: the sum only grows inside a window
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && add_en) |=> (acc_q >= $past(acc_q)));

    // R9: with nothing to add and no restart, the sum holds
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en) |=> $stable(acc_q));

endmodule

// File: rtl/bua_frac_div.sv
// Sequential restoring divider producing floor(numer * (2^FRAC_W-1) / denom),
// clamped to all ones when numer >= denom. One quotient bit per cycle,
// FRAC_W cycles from start to done. A new start abandons a running division.
// Assumes denom is never zero.
module bua_frac_div #(
    parameter int unsigned NUM_W  = 32,
    parameter int unsigned DEN_W  = 32,
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_W-1:0]  numer,
    input  logic [DEN_W-1:0]  denom,
    output logic [FRAC_W-1:0] frac,
    output logic              done
);

    localparam int unsigned CMP_W  = (NUM_W > DEN_W) ? NUM_W : DEN_W;
    localparam int unsigned PROD_W = NUM_W + FRAC_W;
    localparam int unsigned CNT_W  = $clog2(FRAC_W + 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] prod_hi;
    logic              sat_in;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [FRAC_W-1:0] lo_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic              sat_q;
    logic [DEN_W:0]    shifted;
    logic [DEN_W:0]    diff;
    logic              ge;
    logic [FRAC_W-1:0] q_nxt;

    // Scaled numerator: numer * 2^FRAC_W - numer
    always_comb begin
        prod    = {numer, {FRAC_W{1'b0}}} - PROD_W'(numer);
        prod_hi = prod >> FRAC_W;
        sat_in  = CMP_W'(numer) >= CMP_W'(denom);
    end

    // One restoring step
    always_comb begin
        shifted = {rem_q, lo_q[FRAC_W-1]};
        diff    = shifted - {1'b0, den_q};
        ge      = shifted >= {1'b0, den_q};
        q_nxt   = {lo_q[FRAC_W-2:0], ge};
    end

    // Division state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= DEN_W'(1);
            lo_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            sat_q  <= 1'b0;
            frac   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= sat_in ? '0 : DEN_W'(prod_hi);
                den_q  <= denom;
                lo_q   <= prod[FRAC_W-1:0];
                cnt_q  <= CNT_W'(FRAC_W);
                busy_q <= 1'b1;
                sat_q  <= sat_in;
            end else if (busy_q) begin
                rem_q <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                lo_q  <= q_nxt;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    frac   <= sat_q ? '1 : q_nxt;
                end
            end
        end
    end

    // R7: partial remainder stays below the divisor throughout a division
    assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < den_q));

    // R7: a result only appears at the end of a running division
    assert_done_from_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy_q) && !busy_q));

endmodule

// File: rtl/bus_util_acct.sv
// Bus cycle utilization accountant. Charges each reported transaction its
// bus cycles, sums total/read/write per window, latches the sums when the
// window closes and computes the utilization fraction sequentially.
// Assumes at most one report per cycle and windows of 17+ cycles when a
// fraction is wanted every window.
module bus_util_acct
    import bua_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LAT_W  = 8,
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned WIN_W  = 32,
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              txn_valid,
    input  logic [1:0]        txn_kind,
    input  logic [DATA_W-1:0] txn_data,
    input  logic [LAT_W-1:0]  txn_lat,
    output logic [ACC_W-1:0]  total_cyc,
    output logic [ACC_W-1:0]  rd_cyc,
    output logic [ACC_W-1:0]  wr_cyc,
    output logic [FRAC_W-1:0] util_frac,
    output logic              win_done,
    output logic              util_done
);

    localparam int unsigned COST_W = ((DATA_W > LAT_W) ? DATA_W : LAT_W) + 2;

    logic [COST_W-1:0] cost;
    logic              is_read;
    logic              tick;
    logic [WIN_W-1:0]  win_eff;
    logic [N_LANES-1:0] lane_en;
    logic [ACC_W-1:0]  lane_sum [N_LANES];

    bua_cost #(
        .DATA_W (DATA_W),
        .LAT_W  (LAT_W),
        .COST_W (COST_W)
    ) u_cost (
        .kind     (txn_kind),
        .data_cyc (txn_data),
        .lat_cyc  (txn_lat),
        .cost     (cost),
        .is_read  (is_read)
    );

    bua_window #(
        .WIN_W (WIN_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_len (win_len),
        .tick    (tick),
        .win_eff (win_eff)
    );

    // Lane enables: 0 total, 1 read kinds, 2 write kinds
    always_comb begin
        lane_en[0] = txn_valid;
        lane_en[1] = txn_valid & is_read;
        lane_en[2] = txn_valid & ~is_read;
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        bua_sat_acc #(
            .ACC_W (ACC_W),
            .ADD_W (COST_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (tick),
            .add_en  (lane_en[g]),
            .add_val (cost),
            .acc_q   (lane_sum[g])
        );
    end

    // Publish the closed window's sums
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_cyc <= '0;
            rd_cyc    <= '0;
            wr_cyc    <= '0;
            win_done  <= 1'b0;
        end else begin
            win_done <= tick;
            if (tick) begin
                total_cyc <= lane_sum[0];
                rd_cyc    <= lane_sum[1];
                wr_cyc    <= lane_sum[2];
            end
        end
    end

    bua_frac_div #(
        .NUM_W  (ACC_W),
        .DEN_W  (WIN_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tick),
        .numer (lane_sum[0]),
        .denom (win_eff),
        .frac  (util_frac),
        .done  (util_done)
    );

    // R4: the published total is never below either subtotal
    assert_total_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (total_cyc >= rd_cyc) && (total_cyc >= wr_cyc));

    // R8: reset leaves outputs and strobes cleared
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (total_cyc == '0 && rd_cyc == '0 && wr_cyc == '0 &&
                    util_frac == '0 && !win_done && !util_done));

    // R5: published sums change only when a window closes
    assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(total_cyc) || $past(!rst_n));

endmodule

// File: tb/sim_bus_util_acct.sv
`timescale 1ns/1ps
module sim_bus_util_acct;

    localparam int ACC_W = 12;
    localparam int WIN   = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] win_len;
    logic        txn_valid;
    logic [1:0]  txn_kind;
    logic [7:0]  txn_data;
    logic [7:0]  txn_lat;
    logic [ACC_W-1:0] total_cyc, rd_cyc, wr_cyc;
    logic [15:0] util_frac;
    logic        win_done, util_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_util_acct #(.ACC_W(ACC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .win_len(win_len),
        .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_data(txn_data), .txn_lat(txn_lat),
        .total_cyc(total_cyc), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc),
        .util_frac(util_frac), .win_done(win_done), .util_done(util_done)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] d;
        logic [7:0] r;
        logic [9:0] cost;
        logic       rd;
    } vec_t;

    // kind 0 DMA rd (3+R+D), 1 DMA wr (2+R+D), 2 host wr (7), 3 host rd (7)
    localparam vec_t VEC [8] = '{
        '{2'd0, 8'd4,  8'd2,  10'd9,  1'b1},
        '{2'd1, 8'd4,  8'd2,  10'd8,  1'b0},
        '{2'd2, 8'd5,  8'd9,  10'd7,  1'b0},
        '{2'd3, 8'd0,  8'd0,  10'd7,  1'b1},
        '{2'd0, 8'd0,  8'd0,  10'd3,  1'b1},
        '{2'd1, 8'd16, 8'd0,  10'd18, 1'b0},
        '{2'd0, 8'd16, 8'd8,  10'd27, 1'b1},
        '{2'd1, 8'd30, 8'd20, 10'd52, 1'b0}
    };

    function automatic int exp_util(int cost, int win);
        longint p;
        if (cost >= win) return 65535;
        p = longint'(cost) * 65535;
        return int'(p / win);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [1:0] k, logic [7:0] d, logic [7:0] r);
        txn_valid = v; txn_kind = k; txn_data = d; txn_lat = r;
    endtask

    task automatic wait_win();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!win_done && n < 500);
        if (!win_done) chk("R5 win_done timeout", 0, 1);
    endtask

    // Counts cycles until util_done, starting from lat0
    task automatic wait_util(input int lat0, output int lat);
        lat = lat0;
        while (!util_done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        int lat;
        int prev_cost;
        logic prev_rd;
        rst_n = 1'b0;
        win_len = WIN;
        drive(1'b0, 2'd0, 8'd0, 8'd0);
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 total", int'(total_cyc), 0);
        chk("R8 util", int'(util_frac), 0);
        chk("R8 strobes", int'({win_done, util_done}), 0);
        rst_n = 1'b1;

        // Table walk: one report per window, R1 R2 R3 R4 R7
        wait_win();
        prev_cost = 0; prev_rd = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R4 total", int'(total_cyc), prev_cost);
            chk("R4 rd", int'(rd_cyc), prev_rd ? prev_cost : 0);
            chk("R4 wr", int'(wr_cyc), prev_rd ? 0 : prev_cost);
            drive(1'b1, VEC[i].kind, VEC[i].d, VEC[i].r);
            @(negedge clk);
            chk("R5 win_done width", int'(win_done), 0);
            drive(1'b0, 2'd0, 8'd0, 8'd0);
            wait_util(1, lat);
            chk("R7 latency", lat, 16);
            chk("R7 util", int'(util_frac), exp_util(prev_cost, WIN));
            wait_win();
            prev_cost = int'(VEC[i].cost); prev_rd = VEC[i].rd;
            // R1 R2 R3: charged cost of vector i
            chk(VEC[i].kind == 2'd0 ? "R1 cost" : VEC[i].kind == 2'd1 ? "R2 cost" : "R3 cost",
                int'(total_cyc), prev_cost);
        end
        wait_util(0, lat);
        chk("R7 util saturated", int'(util_frac), exp_util(52, WIN));

        // R4 R9: several reports in one window, junk fields while idle
        wait_win();
        drive(1'b1, 2'd0, 8'd2, 8'd1);   @(negedge clk);
        drive(1'b1, 2'd1, 8'd3, 8'd0);   @(negedge clk);
        drive(1'b1, 2'd2, 8'd99, 8'd99); @(negedge clk);
        drive(1'b1, 2'd3, 8'd200, 8'd200); @(negedge clk);
        drive(1'b0, 2'd0, 8'd255, 8'd255);
        wait_win();
        chk("R4 mixed total", int'(total_cyc), 25);
        chk("R4 mixed rd", int'(rd_cyc), 13);
        chk("R9 idle junk wr", int'(wr_cyc), 12);
        wait_util(0, lat);
        chk("R7 mixed util", int'(util_frac), exp_util(25, WIN));

        // R5: report on the last cycle and on the closing cycle
        wait_win();
        repeat (38) @(negedge clk);
        drive(1'b1, 2'd2, 8'd0, 8'd0);
        @(negedge clk);
        drive(1'b1, 2'd0, 8'd1, 8'd0);
        @(negedge clk);
        drive(1'b0, 2'd0, 8'd0, 8'd0);
        chk("R5 close strobe", int'(win_done), 1);
        chk("R5 last cycle kept", int'(total_cyc), 7);
        chk("R5 last cycle wr", int'(wr_cyc), 7);
        wait_win();
        chk("R5 boundary moved", int'(total_cyc), 4);
        chk("R5 boundary rd", int'(rd_cyc), 4);

        // R5: zero length acts as one cycle
        win_len = 0;
        repeat (2) @(negedge clk);
        chk("R5 zero len c0", int'(win_done), 1);
        drive(1'b1, 2'd3, 8'd0, 8'd0);
        @(negedge clk);
        drive(1'b0, 2'd0, 8'd0, 8'd0);
        chk("R5 zero len c1", int'(win_done), 1);
        chk("R5 zero len old", int'(total_cyc), 0);
        @(negedge clk);
        chk("R5 zero len new", int'(total_cyc), 7);
        @(negedge clk);
        chk("R5 zero len next", int'(total_cyc), 0);

        // R6: saturation with a narrow accumulator
        win_len = 20;
        wait_win();
        wait_win();
        repeat (10) begin
            drive(1'b1, 2'd0, 8'd255, 8'd255);
            @(negedge clk);
        end
        drive(1'b0, 2'd0, 8'd0, 8'd0);
        wait_win();
        chk("R6 total sat", int'(total_cyc), 4095);
        chk("R6 rd sat", int'(rd_cyc), 4095);
        chk("R6 wr zero", int'(wr_cyc), 0);
        wait_util(0, lat);
        chk("R7 sat util", int'(util_frac), 65535);

        // R8: reset mid-window drops pending sums
        wait_win();
        repeat (3) begin
            drive(1'b1, 2'd2, 8'd0, 8'd0);
            @(negedge clk);
        end
        drive(1'b0, 2'd0, 8'd0, 8'd0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 mid reset total", int'(total_cyc), 0);
        chk("R8 mid reset util", int'(util_frac), 0);
        rst_n = 1'b1;
        wait_win();
        chk("R8 pending dropped", int'(total_cyc), 0);

        finish_run();
    end

endmodule